// File: doc/BRIEF.md
# Per-Source Software Interrupt Pending Tracker

This block holds the pending state of software-generated interrupts inside a small multiprocessor interrupt distributor. Rather than one bit per interrupt, it stores a separate bit for every combination of interrupt number, requesting (source) core and receiving (target) core. A core raises an interrupt through a generate request that names itself, the interrupt number and a mask of targets. Software can also set or clear individual source bits through a register-style write port and read them back.

For each target, a summary view gives one bit per interrupt: the OR of all source bits held for that interrupt and target. Writes aimed at the summary view are accepted and dropped. When a target core acknowledges, the block picks the lowest-numbered pending interrupt for that target, then the lowest-numbered source core pending for it. It returns both and clears only that one source bit, so the interrupt stays pending for any other source that still requests it.

Top module: `sgi_src_pend`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit; after reset all source rows read 0, the summary reads 0 and an acknowledge returns the spurious response.
- R2: A cycle with `gen_valid` high sets the bit (gen_id, gen_src, t) for every target t whose bit is set in `gen_tgt_mask`, all in that one clock edge.
- R3: A cycle with `wr_en` high and `wr_kind` = 0 ORs `wr_data` into the source row (wr_id, wr_tgt), where bit s of the row is source core s; `wr_kind` = 1 clears the row bits where `wr_data` is 1.
- R4: `rd_src_bits` shows, one clock after `rd_id`/`rd_tgt` are presented, the source row for that interrupt and target as it stood before that edge.
- R5: `sum_bits[i]` shows, one clock after `sum_tgt` is presented, the OR of all source bits of interrupt i at that target.
- R6: Writes with `wr_kind` = 2 (summary set) or 3 (summary clear) change no pending bit.
- R7: An acknowledge (`ack_valid` with `ack_tgt`) responds on the next clock with `ack_rvalid` = 1, `ack_id` = the lowest interrupt number with any pending source at that target, and `ack_src` = the lowest pending source core for it.
- R8: An acknowledge clears only the selected (interrupt, source, target) bit; other sources' bits for the same interrupt and target, and the same source's bits at other targets, stay set, and the summary bit stays 1 while any remains.
- R9: If nothing is pending at the acknowledging target, the response is `ack_id` = 1023 and `ack_src` = 0, and no bit changes.
- R10: When a set (generate request or `wr_kind` 0) and a clear (`wr_kind` 1 or an acknowledge) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_valid | input | 1 | Generate request strobe |
| gen_src | input | SRC_W | Requesting core of the generate request |
| gen_id | input | ID_W | Interrupt number of the generate request |
| gen_tgt_mask | input | NUM_CORES | Target cores of the generate request |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 set source bits, 1 clear source bits, 2 summary set, 3 summary clear |
| wr_id | input | ID_W | Interrupt number of the write |
| wr_tgt | input | SRC_W | Target core of the write |
| wr_data | input | NUM_CORES | Source-core bit mask of the write |
| rd_id | input | ID_W | Interrupt number of the source-row read |
| rd_tgt | input | SRC_W | Target core of the source-row read |
| rd_src_bits | output | NUM_CORES | Registered source row |
| sum_tgt | input | SRC_W | Target core of the summary view |
| sum_bits | output | NUM_SGI | Registered per-interrupt summary |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_tgt | input | SRC_W | Acknowledging target core |
| ack_rvalid | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Selected interrupt number or 1023 |
| ack_src | output | SRC_W | Selected source core |

## Verification
A corrupted pending bit surfaces at the ports no later than one clock after the matching row read, summary read or acknowledge, since each of those outputs is one register away from the storage. The riskiest faults are an acknowledge that clears a whole row instead of one source, which shows as the summary bit dropping while another source still waits, and a wrong selection order, which shows as an unexpected `ack_src` or `ack_id` on the next response. Set/clear collisions are driven in the same cycle so that a reversed priority appears on the following row read.

// File: rtl/sgi_pend_pkg.sv
package sgi_pend_pkg;
  typedef enum logic [1:0] {
    WR_SET_SRC = 2'd0,
    WR_CLR_SRC = 2'd1,
    WR_SET_SUM = 2'd2,
    WR_CLR_SUM = 2'd3
  } wr_kind_e;

  localparam int ACK_ID_W = 10;
  localparam logic [ACK_ID_W-1:0] SPURIOUS_ID = 10'd1023;
endpackage

// File: rtl/sgi_pend_store.sv
module sgi_pend_store #(
  parameter int NUM_SGI   = 16,
  parameter int NUM_CORES = 8,
  parameter int ID_W      = $clog2(NUM_SGI),
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int TOTAL    = NUM_SGI * NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gen_valid,
  input  logic [SRC_W-1:0]     gen_src,
  input  logic [ID_W-1:0]      gen_id,
  input  logic [NUM_CORES-1:0] gen_tgt_mask,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic [ID_W-1:0]      wr_id,
  input  logic [SRC_W-1:0]     wr_tgt,
  input  logic [NUM_CORES-1:0] wr_data,
  input  logic                 ack_clr_en,
  input  logic [ID_W-1:0]      ack_clr_id,
  input  logic [SRC_W-1:0]     ack_clr_tgt,
  input  logic [SRC_W-1:0]     ack_clr_src,
  output logic [TOTAL-1:0]     pend_flat
);
  // Bit layout: ((id * NUM_CORES) + tgt) * NUM_CORES + src
  logic [TOTAL-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < NUM_SGI; i++) begin
      for (int t = 0; t < NUM_CORES; t++) begin
        for (int s = 0; s < NUM_CORES; s++) begin
          automatic int  b      = ((i * NUM_CORES) + t) * NUM_CORES + s;
          automatic logic row_w = (int'(wr_id) == i) && (int'(wr_tgt) == t);
          automatic logic clr_hit;
          automatic logic set_hit;
          clr_hit = (clr_en && row_w && wr_data[s]) ||
                    (ack_clr_en && int'(ack_clr_id) == i &&
                     int'(ack_clr_tgt) == t && int'(ack_clr_src) == s);
          set_hit = (set_en && row_w && wr_data[s]) ||
                    (gen_valid && int'(gen_id) == i &&
                     gen_tgt_mask[t] && int'(gen_src) == s);
          if (set_hit)      pend_d[b] = 1'b1;
          else if (clr_hit) pend_d[b] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_flat = pend_q;
endmodule

// File: rtl/sgi_src_select.sv
module sgi_src_select #(
  parameter int NUM_SGI   = 16,
  parameter int NUM_CORES = 8,
  parameter int ID_W      = $clog2(NUM_SGI),
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_SGI*NUM_CORES-1:0] rows,
  output logic                         found,
  output logic [ID_W-1:0]              sel_id,
  output logic [SRC_W-1:0]             sel_src
);
  logic [NUM_SGI-1:0]   any_src;
  logic [NUM_CORES-1:0] sel_row;

  always_comb begin
    for (int i = 0; i < NUM_SGI; i++)
      any_src[i] = |rows[i*NUM_CORES +: NUM_CORES];
  end

  // Lowest interrupt number first
  always_comb begin
    found  = 1'b0;
    sel_id = '0;
    for (int i = NUM_SGI - 1; i >= 0; i--) begin
      if (any_src[i]) begin
        found  = 1'b1;
        sel_id = ID_W'(i);
      end
    end
  end

  assign sel_row = rows[int'(sel_id)*NUM_CORES +: NUM_CORES];

  // Lowest source core within the chosen interrupt
  always_comb begin
    sel_src = '0;
    for (int s = NUM_CORES - 1; s >= 0; s--)
      if (sel_row[s]) sel_src = SRC_W'(s);
  end
endmodule

// File: rtl/sgi_src_pend.sv
module sgi_src_pend
  import sgi_pend_pkg::*;
#(
  parameter int NUM_SGI   = 16,
  parameter int NUM_CORES = 8,
  parameter int ID_W      = $clog2(NUM_SGI),
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gen_valid,
  input  logic [SRC_W-1:0]     gen_src,
  input  logic [ID_W-1:0]      gen_id,
  input  logic [NUM_CORES-1:0] gen_tgt_mask,
  input  logic                 wr_en,
  input  logic [1:0]           wr_kind,
  input  logic [ID_W-1:0]      wr_id,
  input  logic [SRC_W-1:0]     wr_tgt,
  input  logic [NUM_CORES-1:0] wr_data,
  input  logic [ID_W-1:0]      rd_id,
  input  logic [SRC_W-1:0]     rd_tgt,
  output logic [NUM_CORES-1:0] rd_src_bits,
  input  logic [SRC_W-1:0]     sum_tgt,
  output logic [NUM_SGI-1:0]   sum_bits,
  input  logic                 ack_valid,
  input  logic [SRC_W-1:0]     ack_tgt,
  output logic                 ack_rvalid,
  output logic [ACK_ID_W-1:0]  ack_id,
  output logic [SRC_W-1:0]     ack_src
);
  localparam int ROW_BITS = NUM_SGI * NUM_CORES;
  localparam int TOTAL    = ROW_BITS * NUM_CORES;

  wr_kind_e                 kind;
  logic                     set_en, clr_en;
  logic [TOTAL-1:0]         pend_flat;
  logic [ROW_BITS-1:0]      ack_rows;
  logic [NUM_SGI-1:0]       sum_d;
  logic                     sel_found;
  logic [ID_W-1:0]          sel_id;
  logic [SRC_W-1:0]         sel_src;

  assign kind   = wr_kind_e'(wr_kind);
  // Summary-view kinds decode to nothing: they never reach the storage.
  assign set_en = wr_en && (kind == WR_SET_SRC);
  assign clr_en = wr_en && (kind == WR_CLR_SRC);

  sgi_pend_store #(
    .NUM_SGI(NUM_SGI), .NUM_CORES(NUM_CORES), .ID_W(ID_W), .SRC_W(SRC_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .gen_valid    (gen_valid),
    .gen_src      (gen_src),
    .gen_id       (gen_id),
    .gen_tgt_mask (gen_tgt_mask),
    .set_en       (set_en),
    .clr_en       (clr_en),
    .wr_id        (wr_id),
    .wr_tgt       (wr_tgt),
    .wr_data      (wr_data),
    .ack_clr_en   (ack_valid && sel_found),
    .ack_clr_id   (sel_id),
    .ack_clr_tgt  (ack_tgt),
    .ack_clr_src  (sel_src),
    .pend_flat    (pend_flat)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SGI; gi++) begin : g_rows
      assign ack_rows[gi*NUM_CORES +: NUM_CORES] =
        pend_flat[(gi*NUM_CORES + int'(ack_tgt))*NUM_CORES +: NUM_CORES];
      assign sum_d[gi] =
        |pend_flat[(gi*NUM_CORES + int'(sum_tgt))*NUM_CORES +: NUM_CORES];
    end
  endgenerate

  sgi_src_select #(
    .NUM_SGI(NUM_SGI), .NUM_CORES(NUM_CORES), .ID_W(ID_W), .SRC_W(SRC_W)
  ) u_select (
    .rows    (ack_rows),
    .found   (sel_found),
    .sel_id  (sel_id),
    .sel_src (sel_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src_bits <= '0;
      sum_bits    <= '0;
      ack_rvalid  <= 1'b0;
      ack_id      <= SPURIOUS_ID;
      ack_src     <= '0;
    end else begin
      rd_src_bits <= pend_flat[(int'(rd_id)*NUM_CORES + int'(rd_tgt))*NUM_CORES +: NUM_CORES];
      sum_bits    <= sum_d;
      ack_rvalid  <= ack_valid;
      if (ack_valid) begin
        ack_id  <= sel_found ? ACK_ID_W'(sel_id) : SPURIOUS_ID;
        ack_src <= sel_found ? sel_src : '0;
      end
    end
  end
endmodule

// File: rtl/sgi_src_pend_chk.sv
module sgi_src_pend_chk
  import sgi_pend_pkg::*;
#(
  parameter int NUM_SGI   = 16,
  parameter int NUM_CORES = 8,
  parameter int ID_W      = $clog2(NUM_SGI),
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int TOTAL    = NUM_SGI * NUM_CORES * NUM_CORES
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gen_valid,
  input logic [SRC_W-1:0]     gen_src,
  input logic [ID_W-1:0]      gen_id,
  input logic [NUM_CORES-1:0] gen_tgt_mask,
  input logic                 wr_en,
  input logic [1:0]           wr_kind,
  input logic                 ack_valid,
  input logic [SRC_W-1:0]     ack_tgt,
  input logic                 ack_rvalid,
  input logic [ACK_ID_W-1:0]  ack_id,
  input logic [SRC_W-1:0]     ack_src,
  input logic [TOTAL-1:0]     pend_flat
);
  logic [TOTAL-1:0]     prev_flat;
  logic [SRC_W-1:0]     tgt_q, gsrc_q;
  logic [ID_W-1:0]      gid_q;
  logic [NUM_CORES-1:0] gmask_q;
  logic                 quiet_q, gen_q, seen_clk;
  logic                 prev_any;
  int                   ack_bit;

  always_ff @(posedge clk) begin
    prev_flat <= pend_flat;
    tgt_q     <= ack_tgt;
    gsrc_q    <= gen_src;
    gid_q     <= gen_id;
    gmask_q   <= gen_tgt_mask;
    gen_q     <= gen_valid && !rst;
    quiet_q   <= !gen_valid && !wr_en;
    seen_clk  <= 1'b1;
  end

  always_comb begin
    prev_any = 1'b0;
    for (int i = 0; i < NUM_SGI; i++)
      prev_any = prev_any |
        (|prev_flat[(i*NUM_CORES + int'(tgt_q))*NUM_CORES +: NUM_CORES]);
    ack_bit = ((int'(ack_id[ID_W-1:0])*NUM_CORES) + int'(tgt_q))*NUM_CORES + int'(ack_src);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    disable iff (rst) (seen_clk && $past(rst)) |-> (pend_flat == '0));

  genvar gt;
  generate
    for (gt = 0; gt < NUM_CORES; gt++) begin : g_gen
      assert_gen_sets_R2: assert property (@(posedge clk)
        disable iff (rst) (seen_clk && gen_q && gmask_q[gt]) |->
          pend_flat[((int'(gid_q)*NUM_CORES) + gt)*NUM_CORES + int'(gsrc_q)]);
    end
  endgenerate

  assert_summary_write_inert_R6: assert property (@(posedge clk)
    disable iff (rst) (wr_en && wr_kind[1] && !gen_valid && !ack_valid)
      |=> (pend_flat == $past(pend_flat)));

  assert_ack_was_pending_R7: assert property (@(posedge clk)
    disable iff (rst) (seen_clk && ack_rvalid && ack_id != SPURIOUS_ID)
      |-> prev_flat[ack_bit]);

  assert_ack_clears_one_R8: assert property (@(posedge clk)
    disable iff (rst) (seen_clk && ack_rvalid && ack_id != SPURIOUS_ID && quiet_q)
      |-> (!pend_flat[ack_bit] &&
           $countones(prev_flat ^ pend_flat) == 1));

  assert_spurious_empty_R9: assert property (@(posedge clk)
    disable iff (rst) (seen_clk && ack_rvalid && ack_id == SPURIOUS_ID)
      |-> (!prev_any && ack_src == '0));
endmodule

bind sgi_src_pend sgi_src_pend_chk #(
  .NUM_SGI(NUM_SGI), .NUM_CORES(NUM_CORES), .ID_W(ID_W), .SRC_W(SRC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .gen_valid    (gen_valid),
  .gen_src      (gen_src),
  .gen_id       (gen_id),
  .gen_tgt_mask (gen_tgt_mask),
  .wr_en        (wr_en),
  .wr_kind      (wr_kind),
  .ack_valid    (ack_valid),
  .ack_tgt      (ack_tgt),
  .ack_rvalid   (ack_rvalid),
  .ack_id       (ack_id),
  .ack_src      (ack_src),
  .pend_flat    (pend_flat)
);

// File: tb/tb_sgi_src_pend.sv
`timescale 1ns/1ps
module tb_sgi_src_pend;
  localparam int NS = 16;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gen_valid = 1'b0;
  logic [2:0]    gen_src = '0;
  logic [3:0]    gen_id = '0;
  logic [NC-1:0] gen_tgt_mask = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = '0;
  logic [3:0]    wr_id = '0;
  logic [2:0]    wr_tgt = '0;
  logic [NC-1:0] wr_data = '0;
  logic [3:0]    rd_id = '0;
  logic [2:0]    rd_tgt = '0;
  logic [NC-1:0] rd_src_bits;
  logic [2:0]    sum_tgt = '0;
  logic [NS-1:0] sum_bits;
  logic          ack_valid = 1'b0;
  logic [2:0]    ack_tgt = '0;
  logic          ack_rvalid;
  logic [9:0]    ack_id;
  logic [2:0]    ack_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sgi_src_pend #(.NUM_SGI(NS), .NUM_CORES(NC)) dut (
    .clk(clk), .rst(rst),
    .gen_valid(gen_valid), .gen_src(gen_src), .gen_id(gen_id), .gen_tgt_mask(gen_tgt_mask),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_id(wr_id), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .rd_id(rd_id), .rd_tgt(rd_tgt), .rd_src_bits(rd_src_bits),
    .sum_tgt(sum_tgt), .sum_bits(sum_bits),
    .ack_valid(ack_valid), .ack_tgt(ack_tgt),
    .ack_rvalid(ack_rvalid), .ack_id(ack_id), .ack_src(ack_src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_gen(input int src, input int id, input logic [NC-1:0] mask);
    @(negedge clk);
    gen_valid = 1; gen_src = 3'(src); gen_id = 4'(id); gen_tgt_mask = mask;
    @(negedge clk);
    gen_valid = 0; gen_tgt_mask = '0;
  endtask

  task automatic do_wr(input int kind, input int id, input int tgt, input logic [NC-1:0] data);
    @(negedge clk);
    wr_en = 1; wr_kind = 2'(kind); wr_id = 4'(id); wr_tgt = 3'(tgt); wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_row(input int id, input int tgt, output logic [NC-1:0] v);
    @(negedge clk);
    rd_id = 4'(id); rd_tgt = 3'(tgt);
    @(negedge clk);
    v = rd_src_bits;
  endtask

  task automatic rd_sum(input int tgt, output logic [NS-1:0] v);
    @(negedge clk);
    sum_tgt = 3'(tgt);
    @(negedge clk);
    v = sum_bits;
  endtask

  task automatic do_ack(input int tgt, output logic [9:0] id, output logic [2:0] src);
    @(negedge clk);
    ack_valid = 1; ack_tgt = 3'(tgt);
    @(negedge clk);
    ack_valid = 0;
    chk("R7 ack_rvalid", 32'(ack_rvalid), 1);
    id = ack_id; src = ack_src;
  endtask

  task automatic t_reset();
    logic [NC-1:0] r; logic [NS-1:0] s; logic [9:0] id; logic [2:0] src;
    rd_row(0, 0, r);  chk("R1 row after reset", 32'(r), 0);
    rd_row(15, 7, r); chk("R1 last row after reset", 32'(r), 0);
    rd_sum(3, s);     chk("R1 summary after reset", 32'(s), 0);
    do_ack(0, id, src);
    chk("R9 spurious id", 32'(id), 1023);
    chk("R9 spurious src", 32'(src), 0);
  endtask

  task automatic t_gen();
    logic [NC-1:0] r; logic [NS-1:0] s;
    do_gen(3, 5, 8'b1001_0010);
    rd_row(5, 1, r); chk("R2 target 1", 32'(r), 32'h08);
    rd_row(5, 4, r); chk("R2 target 4", 32'(r), 32'h08);
    rd_row(5, 7, r); chk("R2 target 7", 32'(r), 32'h08);
    rd_row(5, 0, r); chk("R2 unmasked target 0", 32'(r), 0);
    rd_sum(4, s);    chk("R5 summary target 4", 32'(s), 32'h0020);
  endtask

  task automatic t_regwr();
    logic [NC-1:0] r;
    do_wr(0, 2, 0, 8'h0A);
    rd_row(2, 0, r); chk("R3 R4 set row", 32'(r), 32'h0A);
    do_wr(1, 2, 0, 8'h02);
    rd_row(2, 0, r); chk("R3 clear one bit", 32'(r), 32'h08);
  endtask

  task automatic t_sumwr();
    logic [NC-1:0] r; logic [NS-1:0] s;
    do_wr(2, 2, 0, 8'hFF);
    rd_row(2, 0, r); chk("R6 summary set ignored", 32'(r), 32'h08);
    do_wr(3, 2, 0, 8'hFF);
    rd_row(2, 0, r); chk("R6 summary clear ignored", 32'(r), 32'h08);
    rd_sum(0, s);    chk("R6 R5 summary target 0", 32'(s), 32'h0004);
  endtask

  task automatic t_ack_multi();
    logic [NC-1:0] r; logic [NS-1:0] s; logic [9:0] id; logic [2:0] src;
    do_wr(0, 7, 2, 8'h52);
    do_ack(2, id, src);
    chk("R7 first id", 32'(id), 7);
    chk("R7 lowest source", 32'(src), 1);
    rd_row(7, 2, r); chk("R8 others kept", 32'(r), 32'h50);
    rd_sum(2, s);    chk("R8 summary still set", 32'(s), 32'h0080);
    do_ack(2, id, src); chk("R7 second src", 32'(src), 4);
    do_ack(2, id, src); chk("R7 third src", 32'(src), 6);
    rd_sum(2, s);    chk("R8 summary drops when empty", 32'(s), 0);
    do_ack(2, id, src); chk("R9 drained", 32'(id), 1023);
  endtask

  task automatic t_ack_order();
    logic [9:0] id; logic [2:0] src; logic [NC-1:0] r;
    do_gen(0, 9, 8'h04);
    do_gen(5, 7, 8'h04);
    do_ack(2, id, src);
    chk("R7 lowest id first", 32'(id), 7); chk("R7 src", 32'(src), 5);
    do_ack(2, id, src);
    chk("R7 next id", 32'(id), 9); chk("R7 next src", 32'(src), 0);
    do_ack(4, id, src);
    chk("R7 target 4 id", 32'(id), 5); chk("R7 target 4 src", 32'(src), 3);
    rd_row(5, 1, r); chk("R8 other target kept", 32'(r), 32'h08);
    rd_row(5, 4, r); chk("R8 acked bit cleared", 32'(r), 0);
  endtask

  task automatic t_conflict();
    logic [NC-1:0] r; logic [9:0] id; logic [2:0] src;
    do_wr(0, 3, 5, 8'h01);
    @(negedge clk);
    gen_valid = 1; gen_src = 0; gen_id = 3; gen_tgt_mask = 8'h20;
    wr_en = 1; wr_kind = 1; wr_id = 3; wr_tgt = 5; wr_data = 8'h01;
    @(negedge clk);
    gen_valid = 0; gen_tgt_mask = '0; wr_en = 0;
    rd_row(3, 5, r); chk("R10 set beats register clear", 32'(r), 32'h01);
    do_wr(0, 4, 6, 8'h04);
    @(negedge clk);
    ack_valid = 1; ack_tgt = 6;
    gen_valid = 1; gen_src = 2; gen_id = 4; gen_tgt_mask = 8'h40;
    @(negedge clk);
    ack_valid = 0; gen_valid = 0; gen_tgt_mask = '0;
    chk("R7 ack with collision id", 32'(ack_id), 4);
    chk("R7 ack with collision src", 32'(ack_src), 2);
    rd_row(4, 6, r); chk("R10 set beats ack clear", 32'(r), 32'h04);
    do_ack(5, id, src);
    chk("R7 target 5 id", 32'(id), 3);
    rd_row(3, 5, r); chk("R8 row emptied", 32'(r), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_gen();
    t_regwr();
    t_sumwr();
    t_ack_multi();
    t_ack_order();
    t_conflict();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule